// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This engine sits between an on-chip read bus and one or more serial NOR flash devices. The read address is split into a window index, which picks one chip select, and a byte offset inside that window. A bus read in a mapped window becomes one complete single-bit SPI transaction. The transaction sends an opcode, then the address, then any dummy bytes. It then shifts in four data bytes and returns them as one 32-bit word.

Each chip select has its own 32-bit control word, supplied on a flat input bus. The control word sets the command mode, the opcode, 3-byte or 4-byte addressing, and a 3-bit dummy-byte count. The SPI clock is the system clock divided by four, in SPI mode 0. While a transaction runs, the request port is held off.

Top module: `spirf_read_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `spi_cs_n` bit is high, `spi_sck` is low, `rd_ready` is high and `rsp_valid` is low.
- R2: The window index is `rd_addr[ADDR_W-1 -: CS_W]`. A read in window k drives only `spi_cs_n[k]` low, and the offset is `rd_addr[WIN_BITS-1:0]`.
- R3: The command mode is bits [1:0] of the control word: 0 is normal read, 1 is fast read, 2 is write, 3 is user. A read is refused if the mode is 2 or 3, or if the window index has no chip select. A refused read is accepted and answered in the next cycle with `rsp_valid` high and `rsp_data` zero. No chip select goes low.
- R4: The first byte on `spi_mosi` is control bits [23:16], sent most significant bit first.
- R5: When control bit 13 is clear, the low 24 offset bits follow the opcode as three big-endian bytes.
- R6: When control bit 13 is set, the offset, zero-extended to 32 bits, follows the opcode as four big-endian bytes.
- R7: The dummy count is {bit 14, bits [7:6]}. In fast-read mode that many 0xFF bytes follow the address. In normal mode no dummy byte is sent, whatever the count field holds.
- R8: After the header, 32 bits are sampled from `spi_miso` on rising SCK edges, most significant bit first within each byte. The first byte received lands in `rsp_data[7:0]` and the fourth in `rsp_data[31:24]`.
- R9: SCK idles low and each bit takes 2 clocks low then 2 clocks high. The first rising edge comes 2 clocks after chip select falls. Chip select rises 1 clock after the last falling edge. The number of rising edges is the header bits plus 32.
- R10: From acceptance until the response cycle, `rd_ready` is low. A request held valid during that time starts no second transaction.
- R11: `rsp_valid` is a one-cycle pulse. On a launched read, it comes in the cycle chip select rises, with `rd_ready` high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Engine can accept a request |
| rd_addr | input | ADDR_W | Window index and byte offset |
| cfg_words | input | NUM_CS*32 | One control word per chip select, chip select 0 in the low word |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 32 | Four bytes, lowest address in the low byte |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is the data turnaround. The flash's first data bit must already be on `spi_miso` at the falling edge that ends the last header or dummy bit, so the bench flash model counts rising edges itself and starts answering at the header length it expects. Vectors vary the header length over 32 to 96 bits, mixing address widths, dummy counts in both modes, and offsets whose upper bits must be dropped. Holding a request valid across a whole transaction shows that the engine's hold-off admits nothing.

// File: rtl/spirf_pkg.sv
package spirf_pkg;
  localparam int CFG_W    = 32;
  localparam int FLASH_AW = 32;
  localparam int RD_BYTES = 4;
  localparam int RD_BITS  = RD_BYTES * 8;
  localparam int CNT_W    = 8;
  localparam int SCK_DIV  = 4;
  localparam int PHASE_W  = $clog2(SCK_DIV);
  localparam int HALF_DIV = SCK_DIV / 2;
  localparam int TX_W     = 8 + FLASH_AW;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_FAST   = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_USER   = 2'd3
  } cmd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } seq_state_e;

  typedef struct packed {
    cmd_mode_e   mode;
    logic [7:0]  opcode;
    logic        wide_addr;
    logic [2:0]  dummy_bytes;
  } rd_cfg_t;
endpackage

// File: rtl/spirf_cfg_sel.sv
module spirf_cfg_sel import spirf_pkg::*; #(
  parameter int NUM_CS = 3,
  parameter int CS_W   = 2
) (
  input  logic [NUM_CS*CFG_W-1:0] cfg_words,
  input  logic [CS_W-1:0]         cs_idx,
  output rd_cfg_t                 cfg,
  output logic                    cs_ok
);
  rd_cfg_t dec [NUM_CS];
  logic [NUM_CS-1:0] unused_cfg_bits;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_dec
    logic [CFG_W-1:0] word;
    assign word = cfg_words[g*CFG_W +: CFG_W];
    // mode [1:0], opcode [23:16], wide [13], dummy {14, 7:6}
    assign dec[g] = {word[1:0], word[23:16], word[13], word[14], word[7:6]};
    assign unused_cfg_bits[g] = ^{word[31:24], word[15], word[12:8], word[5:2]};
  end

  always_comb begin
    cfg   = '0;
    cs_ok = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_idx == CS_W'(i)) begin
        cfg   = dec[i];
        cs_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spirf_seq.sv
module spirf_seq import spirf_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] hdr_bits,
  input  logic [CNT_W-1:0] data_start,
  input  logic [CNT_W-1:0] last_bit,
  output seq_state_e       state,
  output logic             sck,
  output logic             bit_end,
  output logic             in_hdr,
  output logic             sample_en,
  output logic             active
);
  seq_state_e         state_q, state_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   hdr_q, dstart_q, last_q;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SHIFT;
          phase_d = '0;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        phase_d = phase_q + 1'b1;
        if (phase_q == PHASE_W'(SCK_DIV-1)) begin
          if (cnt_q == last_q) state_d = ST_TAIL;
          else                 cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q    <= '0;
      dstart_q <= '0;
      last_q   <= '0;
    end else if (start && state_q == ST_IDLE) begin
      hdr_q    <= hdr_bits;
      dstart_q <= data_start;
      last_q   <= last_bit;
    end
  end

  assign state     = state_q;
  assign active    = (state_q == ST_SHIFT);
  assign sck       = active && (phase_q >= PHASE_W'(HALF_DIV));
  assign bit_end   = active && (phase_q == PHASE_W'(SCK_DIV-1));
  assign sample_en = active && (phase_q == PHASE_W'(HALF_DIV)) && (cnt_q >= dstart_q);
  assign in_hdr    = (cnt_q < hdr_q);

  // R9: the bit counter never runs past the latched transaction length
  assert_bit_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (cnt_q <= last_q));
  // R9: a transaction always ends through the tail cycle before idle
  assert_tail_before_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/spirf_shifter.sv
module spirf_shifter import spirf_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [7:0]          opcode,
  input  logic                wide,
  input  logic [FLASH_AW-1:0] flash_addr,
  input  logic                shift_en,
  input  logic                active,
  input  logic                in_hdr,
  input  logic                sample_en,
  input  logic                miso,
  output logic                mosi,
  output logic [RD_BITS-1:0]  rx_word
);
  logic [TX_W-1:0]    tx_q, tx_d;
  logic [RD_BITS-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load) begin
      if (wide) tx_d = {opcode, flash_addr};
      else      tx_d = {opcode, flash_addr[23:0], 8'hFF};
    end else if (shift_en) begin
      tx_d = {tx_q[TX_W-2:0], 1'b1};
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (load)           rx_d = '0;
    else if (sample_en) rx_d = {rx_q[RD_BITS-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '1;
      rx_q <= '0;
    end else begin
      if (load || shift_en)  tx_q <= tx_d;
      if (load || sample_en) rx_q <= rx_d;
    end
  end

  // header bits from the shift register, then a constant high line
  assign mosi = (active && in_hdr) ? tx_q[TX_W-1] : 1'b1;

  // first byte shifted in holds the lowest address: move it to the low lane
  for (genvar b = 0; b < RD_BYTES; b++) begin : g_swap
    assign rx_word[b*8 +: 8] = rx_q[(RD_BYTES-1-b)*8 +: 8];
  end
endmodule

// File: rtl/spirf_read_engine.sv
module spirf_read_engine import spirf_pkg::*; #(
  parameter  int NUM_CS   = 3,
  parameter  int WIN_BITS = 26,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int ADDR_W   = CS_W + WIN_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [NUM_CS*CFG_W-1:0] cfg_words,
  output logic                    rsp_valid,
  output logic [RD_BITS-1:0]      rsp_data,
  output logic [NUM_CS-1:0]       spi_cs_n,
  output logic                    spi_sck,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  logic [CS_W-1:0]     cs_idx;
  logic [WIN_BITS-1:0] win_off;
  rd_cfg_t             cfg;
  logic                cs_ok, mode_ok;
  logic                accept, launch, refuse;
  logic [2:0]          dummy_n;
  logic [CNT_W-1:0]    hdr_bits, data_start, last_bit;
  logic [FLASH_AW-1:0] flash_addr;
  seq_state_e          state;
  logic                bit_end, in_hdr, sample_en, active;
  logic [RD_BITS-1:0]  rx_word;
  logic [NUM_CS-1:0]   sel_q, sel_d;
  logic                rsp_valid_q, rsp_valid_d;
  logic [RD_BITS-1:0]  rsp_data_q, rsp_data_d;

  assign cs_idx  = rd_addr[ADDR_W-1 -: CS_W];
  assign win_off = rd_addr[WIN_BITS-1:0];

  spirf_cfg_sel #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_sel (
    .cfg_words (cfg_words),
    .cs_idx    (cs_idx),
    .cfg       (cfg),
    .cs_ok     (cs_ok)
  );

  assign rd_ready = (state == ST_IDLE);
  assign mode_ok  = (cfg.mode == MODE_NORMAL) || (cfg.mode == MODE_FAST);
  assign accept   = rd_valid && rd_ready;
  assign launch   = accept && cs_ok && mode_ok;
  assign refuse   = accept && !(cs_ok && mode_ok);

  assign dummy_n    = (cfg.mode == MODE_FAST) ? cfg.dummy_bytes : 3'd0;
  assign hdr_bits   = cfg.wide_addr ? CNT_W'(8 + 32) : CNT_W'(8 + 24);
  assign data_start = hdr_bits + CNT_W'({dummy_n, 3'b000});
  assign last_bit   = data_start + CNT_W'(RD_BITS - 1);
  assign flash_addr = FLASH_AW'(win_off);

  spirf_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (launch),
    .hdr_bits   (hdr_bits),
    .data_start (data_start),
    .last_bit   (last_bit),
    .state      (state),
    .sck        (spi_sck),
    .bit_end    (bit_end),
    .in_hdr     (in_hdr),
    .sample_en  (sample_en),
    .active     (active)
  );

  spirf_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (launch),
    .opcode     (cfg.opcode),
    .wide       (cfg.wide_addr),
    .flash_addr (flash_addr),
    .shift_en   (bit_end),
    .active     (active),
    .in_hdr     (in_hdr),
    .sample_en  (sample_en),
    .miso       (spi_miso),
    .mosi       (spi_mosi),
    .rx_word    (rx_word)
  );

  always_comb begin
    sel_d = sel_q;
    if (launch) sel_d = NUM_CS'(1) << cs_idx;
  end

  always_comb begin
    rsp_valid_d = refuse || (state == ST_TAIL);
    rsp_data_d  = (state == ST_TAIL) ? rx_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (launch) sel_q <= sel_d;
      rsp_valid_q <= rsp_valid_d;
      if (rsp_valid_d) rsp_data_q <= rsp_data_d;
    end
  end

  assign spi_cs_n  = (state != ST_IDLE) ? ~sel_q : '1;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // R2: never more than one chip select low
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  // R9: the serial clock only pulses inside a selected transaction
  assert_sck_inside_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !(&spi_cs_n));
  // R9: chip select is released only after the clock has returned low
  assert_release_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&spi_cs_n) |-> !$past(spi_sck));
  // R10: no request is taken while a chip select is active
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(&spi_cs_n) |-> !rd_ready);
  // R3: refused reads answer at once with zero and stay off the bus
  assert_refuse_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (rsp_valid && (rsp_data == '0) && (&spi_cs_n)));
endmodule

// File: tb/sim_spirf_read_engine.sv
`timescale 1ns/1ps
module sim_spirf_read_engine;
  localparam int NUM_CS   = 3;
  localparam int WIN_BITS = 26;
  localparam int CS_W     = 2;
  localparam int ADDR_W   = CS_W + WIN_BITS;
  localparam int NVEC     = 8;

  // {control word, 4'b0, window index, offset}
  localparam logic [63:0] VECS [NVEC] = '{
    {32'h0003_0000, 4'h0, 2'd0, 26'h0012345},  // normal, 3-byte
    {32'h000B_0041, 4'h0, 2'd1, 26'h00ABCDE},  // fast, 1 dummy
    {32'h0013_2000, 4'h0, 2'd2, 26'h2345678},  // normal, 4-byte
    {32'h000C_60C1, 4'h0, 2'd0, 26'h1000001},  // fast, 7 dummy, 4-byte
    {32'h0003_4080, 4'h0, 2'd1, 26'h3000010},  // normal, count 6 ignored
    {32'h000B_4001, 4'h0, 2'd2, 26'h0000007},  // fast, 4 dummy
    {32'h800B_0021, 4'h0, 2'd0, 26'h0FFFFFF},  // fast, 0 dummy, stray bits
    {32'h00EC_2001, 4'h0, 2'd1, 26'h3FFFFFF}   // fast, 0 dummy, 4-byte
  };

  logic clk = 1'b0;
  logic rst_n;
  logic rd_valid, rd_ready;
  logic [ADDR_W-1:0] rd_addr;
  logic [NUM_CS*32-1:0] cfg_words;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [NUM_CS-1:0] spi_cs_n;
  logic spi_sck, spi_mosi, miso_r;

  always #2 clk = ~clk;

  spirf_read_engine #(.NUM_CS(NUM_CS), .WIN_BITS(WIN_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .cfg_words(cfg_words), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(miso_r)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always @(negedge clk) cyc = cyc + 1;

  function automatic logic [7:0] flash_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A ^ {a[2:0], 5'b0};
  endfunction

  // flash model and bus monitor
  int nbits, data_start_exp, cs_falls, t_cs_fall, t_cs_rise, t_first_rise, t_last_fall, idx;
  logic [31:0] addr_exp;
  logic [7:0] cap [16];
  logic [NUM_CS-1:0] cs_seen;
  bit first_pending;
  wire cs_any = ~&spi_cs_n;

  always @(posedge cs_any) begin
    cs_falls++;
    t_cs_fall = cyc;
    nbits = 0;
    first_pending = 1;
    cs_seen = ~spi_cs_n;
    miso_r = 1'b0;
    for (int i = 0; i < 16; i++) cap[i] = 8'h00;
  end
  always @(negedge cs_any) t_cs_rise = cyc;
  always @(posedge spi_sck) begin
    if (first_pending) begin t_first_rise = cyc; first_pending = 0; end
    if (nbits < 128) cap[nbits/8][7 - nbits%8] = spi_mosi;
    nbits++;
  end
  always @(negedge spi_sck) begin
    logic [7:0] b;
    t_last_fall = cyc;
    if (nbits >= data_start_exp && nbits - data_start_exp < 32) begin
      idx = nbits - data_start_exp;
      b = flash_byte(addr_exp + 32'(idx / 8));
      miso_r = b[7 - idx%8];
    end else miso_r = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_rsp(output bit got);
    got = 0;
    for (int n = 0; n < 1000; n++) begin
      @(negedge clk);
      if (rsp_valid) begin got = 1; break; end
    end
  endtask

  task automatic run_vec(input int cs, input logic [31:0] cfg, input logic [25:0] off, input bit hold);
    logic [1:0] mode;
    bit fourb, got;
    int nd, ab, f0;
    logic [31:0] exp_data;
    logic [7:0] hb [16];
    mode  = cfg[1:0];
    fourb = cfg[13];
    nd    = (mode == 2'd1) ? int'({cfg[14], cfg[7:6]}) : 0;
    ab    = fourb ? 4 : 3;
    addr_exp = fourb ? {6'b0, off} : {8'h00, off[23:0]};
    data_start_exp = 8 * (1 + ab + nd);
    for (int i = 0; i < 16; i++) hb[i] = 8'hFF;
    hb[0] = cfg[23:16];
    for (int i = 0; i < ab; i++) hb[1+i] = addr_exp[(ab-1-i)*8 +: 8];
    for (int k = 0; k < 4; k++) exp_data[k*8 +: 8] = flash_byte(addr_exp + 32'(k));

    @(negedge clk);
    cfg_words[cs*32 +: 32] = cfg;
    f0 = cs_falls;
    chk(rd_ready == 1'b1, "R10 ready when idle", 64'(rd_ready), 1);
    rd_addr  = {cs[1:0], off};
    rd_valid = 1'b1;
    if (!hold) begin
      @(negedge clk);
      rd_valid = 1'b0;
    end else begin
      repeat (5) @(negedge clk);
      chk(rd_ready == 1'b0, "R10 held off while busy", 64'(rd_ready), 0);
    end
    wait_rsp(got);
    rd_valid = 1'b0;
    chk(got, "R8 response arrives", 64'(got), 1);
    chk(rsp_data == exp_data, "R8 data word", 64'(rsp_data), 64'(exp_data));
    chk(cs_seen == NUM_CS'(1 << cs), "R2 chip select", 64'(cs_seen), 64'(1 << cs));
    chk(cap[0] == hb[0], "R4 opcode", 64'(cap[0]), 64'(hb[0]));
    if (fourb)
      chk({cap[1], cap[2], cap[3], cap[4]} == addr_exp, "R6 address", {cap[1], cap[2], cap[3], cap[4]}, 64'(addr_exp));
    else
      chk({cap[1], cap[2], cap[3]} == addr_exp[23:0], "R5 address", {cap[1], cap[2], cap[3]}, 64'(addr_exp[23:0]));
    for (int i = 0; i < nd; i++)
      chk(cap[1+ab+i] == 8'hFF, "R7 dummy byte", 64'(cap[1+ab+i]), 64'hFF);
    chk(nbits == data_start_exp + 32, "R7 R9 edge count", 64'(nbits), 64'(data_start_exp + 32));
    chk(t_first_rise - t_cs_fall == 2, "R9 select to first edge", 64'(t_first_rise - t_cs_fall), 2);
    chk(t_cs_rise - t_last_fall == 1, "R9 last edge to release", 64'(t_cs_rise - t_last_fall), 1);
    chk(rd_ready && (&spi_cs_n), "R11 ready with response", 64'({rd_ready, spi_cs_n}), 64'({1'b1, {NUM_CS{1'b1}}}));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single pulse", 64'(rsp_valid), 0);
    repeat (6) @(negedge clk);
    chk(cs_falls == f0 + 1, "R10 one transaction", 64'(cs_falls), 64'(f0 + 1));
  endtask

  task automatic refuse_case(input int cs, input logic [31:0] cfg, input string tag);
    int f0;
    @(negedge clk);
    if (cs < NUM_CS) cfg_words[cs*32 +: 32] = cfg;
    f0 = cs_falls;
    rd_addr  = {cs[1:0], 26'h0000100};
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_valid && rsp_data == 32'h0, tag, {rsp_valid, rsp_data}, 64'h1_0000_0000);
    repeat (8) @(negedge clk);
    chk(cs_falls == f0 && !rsp_valid, "R3 no bus activity", 64'(cs_falls), 64'(f0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rd_valid = 1'b0;
    rd_addr = '0;
    cfg_words = '0;
    miso_r = 1'b0;
    cs_falls = 0;
    data_start_exp = 0;
    repeat (3) @(negedge clk);
    chk((&spi_cs_n) && !spi_sck && rd_ready && !rsp_valid, "R1 in reset",
        64'({spi_cs_n, spi_sck, rd_ready, rsp_valid}), 64'({{NUM_CS{1'b1}}, 3'b010}));
    rst_n = 1'b1;
    @(negedge clk);
    chk((&spi_cs_n) && !spi_sck && rd_ready && !rsp_valid, "R1 after reset",
        64'({spi_cs_n, spi_sck, rd_ready, rsp_valid}), 64'({{NUM_CS{1'b1}}, 3'b010}));

    for (int v = 0; v < NVEC; v++)
      run_vec(int'(VECS[v][27:26]), VECS[v][63:32], VECS[v][25:0], 1'b0);

    refuse_case(0, 32'h0003_0002, "R3 write mode refused");
    refuse_case(1, 32'h0003_0003, "R3 user mode refused");
    refuse_case(3, 32'h0, "R3 unmapped window refused");

    // R10: request held valid through a whole transaction
    run_vec(2, 32'h000B_2041, 26'h0155AA3, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule